// File: doc/BRIEF.md
# I2C Read Burst Receiver

This block collects a programmed number of bytes from an I2C bus into a 64-entry receive queue. A control write supplies a byte count and a policy bit for the final acknowledge, and that write launches the burst. An external bit engine produces the bus timing. It pulses `bit_tick` once per sampled SCL high phase and presents the sampled SDA level on `sda_in`. The block assembles each byte MSB first. In the ninth slot it tells the engine whether to pull SDA low (ACK) or release it (NACK).

Each finished byte goes into the queue. When the count runs out, the block raises a sticky read-done flag, and this flag can drive an interrupt. Software drains the queue one byte per `rd_pop` strobe. To read more than 64 bytes, software issues a chain of bursts. Every burst except the final one keeps the final-NACK bit clear, so only the very last byte on the bus is NACKed.

Top module: `i2c_rx_burst`

## Requirements
- R1: After reset, `busy`, `rd_done`, `err`, `irq`, `ack_phase` and `sda_pull_low` are 0, `rx_empty` is 1 and `rd_data` is 0.
- R2: A `ctl_wr` pulse while idle with a nonzero count makes `busy` high from the next cycle. It also clears `rd_done` and `err`. `busy` stays high until the last byte's acknowledge slot has been clocked.
- R3: While busy, each of the first eight `bit_tick` pulses of a byte shifts in `sda_in`, with the first bit as the MSB. After the eighth pulse `ack_phase` is 1, and the ninth pulse pushes the assembled byte into the queue.
- R4: In the acknowledge slot, `sda_pull_low` is 1 (ACK) for every byte except the last. For the last byte it is 0 (NACK) when `ctl_nack_last` was 1 at the start of the burst, and 1 otherwise. Outside the slot it is 0.
- R5: In the cycle after the last byte's ninth pulse, `busy` is 0 and `rd_done` is 1. `irq` equals `rd_done` AND `irq_en`.
- R6: A start with count 0 sets `rd_done` in the next cycle. It never raises `busy` and shifts in no bytes.
- R7: A count above 64 is treated as 64.
- R8: A `ctl_wr` pulse while `busy` is high has no effect on the count or the acknowledge policy of the running burst.
- R9: `rd_data` shows the oldest queued byte. Each `rd_pop` removes one byte, so bytes leave in arrival order. `rx_empty` is 1 exactly when the queue holds nothing.
- R10: `rd_pop` on an empty queue leaves `rd_data` at 0 and sets `err` from the next cycle. `err` stays set until the next accepted start clears it.
- R11: A byte completed while the queue already holds 64 bytes is dropped and sets `err`. The queued bytes are unchanged.
- R12: A push and a pop in the same cycle both take effect.

Parameters: `DEPTH` (queue depth and maximum burst, a power of two, default 64). `ctl_count` is $clog2(DEPTH)+1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe, starts a burst when idle |
| ctl_count | input | 7 | Number of bytes to read |
| ctl_nack_last | input | 1 | 1: NACK the final byte of this burst |
| irq_en | input | 1 | Interrupt enable for read-done |
| bit_tick | input | 1 | One pulse per bit slot from the bit engine |
| sda_in | input | 1 | Sampled SDA level, valid with `bit_tick` |
| ack_phase | output | 1 | The next tick is the acknowledge slot |
| sda_pull_low | output | 1 | Drive SDA low during the acknowledge slot |
| rd_pop | input | 1 | Read-out strobe, removes one byte |
| rd_data | output | 8 | Oldest queued byte, 0 when empty |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | Burst in progress |
| rd_done | output | 1 | Sticky read-complete flag |
| err | output | 1 | Sticky underflow/overflow flag |
| irq | output | 1 | Read-complete interrupt |

## Verification
A byte can reach the queue in the same cycle that software pops one. The bench provokes this by raising `rd_pop` together with the ninth `bit_tick` of a byte while one earlier byte is still queued. It then judges the result at the ports: the new byte must be the only entry left, `err` must stay clear, and the next pop must empty the queue. A related collision is a control write landing in the middle of a burst. The bench confirms that the running burst still ends after its original count and applies its original NACK policy.

// File: rtl/i2c_rxb_pkg.sv
package i2c_rxb_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(BYTE_W);
endpackage

// File: rtl/i2c_rxb_fifo.sv
module i2c_rxb_fifo
  import i2c_rxb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic              empty,
  output logic              overflow,
  output logic              underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic full, do_push, do_pop;

  assign empty     = (wr_q == rd_q);
  assign full      = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign overflow  = push && full;
  assign underflow = pop && empty;
  assign head      = empty ? '0 : mem[rd_q[AW-1:0]];

  always_comb begin
    wr_n = wr_q;
    rd_n = rd_q;
    if (do_push) wr_n = wr_q + PW'(1);
    if (do_pop)  rd_n = rd_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q[AW-1:0]] <= push_data;
  end
endmodule

// File: rtl/i2c_rxb_seq.sv
module i2c_rxb_seq
  import i2c_rxb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              nack_in,
  input  logic              bit_tick,
  input  logic              sda_in,
  output logic              busy,
  output logic              ack_phase,
  output logic              sda_pull_low,
  output logic              push,
  output logic [BYTE_W-1:0] push_data,
  output logic              done_set,
  output logic              start_acc
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

  logic                 busy_q, busy_n;
  logic [BIT_CNT_W-1:0] bit_q, bit_n;
  logic [CNT_W-1:0]     rem_q, rem_n;
  logic                 nack_q, nack_n;
  logic [BYTE_W-1:0]    sh_q, sh_n;
  logic [CNT_W-1:0]     eff_cnt;
  logic                 last_byte;

  assign eff_cnt      = (count_in > MAX_CNT) ? MAX_CNT : count_in;
  assign last_byte    = (rem_q == CNT_W'(1));
  assign busy         = busy_q;
  assign ack_phase    = busy_q && (bit_q == ACK_SLOT);
  assign sda_pull_low = ack_phase && !(last_byte && nack_q);
  assign push_data    = sh_q;

  always_comb begin
    busy_n    = busy_q;
    bit_n     = bit_q;
    rem_n     = rem_q;
    nack_n    = nack_q;
    sh_n      = sh_q;
    push      = 1'b0;
    done_set  = 1'b0;
    start_acc = 1'b0;
    if (start_req && !busy_q) begin
      start_acc = 1'b1;
      if (eff_cnt == '0) begin
        done_set = 1'b1;
      end else begin
        busy_n = 1'b1;
        rem_n  = eff_cnt;
        bit_n  = '0;
        nack_n = nack_in;
      end
    end else if (busy_q && bit_tick) begin
      if (bit_q != ACK_SLOT) begin
        sh_n  = {sh_q[BYTE_W-2:0], sda_in};
        bit_n = bit_q + BIT_CNT_W'(1);
      end else begin
        push  = 1'b1;
        bit_n = '0;
        rem_n = rem_q - CNT_W'(1);
        if (last_byte) begin
          busy_n   = 1'b0;
          done_set = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      rem_q  <= '0;
      nack_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_n;
      bit_q  <= bit_n;
      rem_q  <= rem_n;
      nack_q <= nack_n;
      sh_q   <= sh_n;
    end
  end
endmodule

// File: rtl/i2c_rx_burst.sv
module i2c_rx_burst
  import i2c_rxb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CNT_W-1:0]  ctl_count,
  input  logic              ctl_nack_last,
  input  logic              irq_en,
  input  logic              bit_tick,
  input  logic              sda_in,
  output logic              ack_phase,
  output logic              sda_pull_low,
  input  logic              rd_pop,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rx_empty,
  output logic              busy,
  output logic              rd_done,
  output logic              err,
  output logic              irq
);
  logic              push, done_set, start_acc, ovf, unf;
  logic [BYTE_W-1:0] push_data;
  logic              done_q, done_n, err_q, err_n;

  i2c_rxb_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (ctl_wr),
    .count_in     (ctl_count),
    .nack_in      (ctl_nack_last),
    .bit_tick     (bit_tick),
    .sda_in       (sda_in),
    .busy         (busy),
    .ack_phase    (ack_phase),
    .sda_pull_low (sda_pull_low),
    .push         (push),
    .push_data    (push_data),
    .done_set     (done_set),
    .start_acc    (start_acc)
  );

  i2c_rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (rd_pop),
    .head      (rd_data),
    .empty     (rx_empty),
    .overflow  (ovf),
    .underflow (unf)
  );

  always_comb begin
    done_n = done_q;
    err_n  = err_q;
    if (start_acc) begin
      done_n = 1'b0;
      err_n  = 1'b0;
    end
    if (done_set)   done_n = 1'b1;
    if (ovf || unf) err_n  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign rd_done = done_q;
  assign err     = err_q;
  assign irq     = done_q && irq_en;
endmodule

// File: rtl/i2c_rx_burst_chk.sv
module i2c_rx_burst_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       ack_phase,
  input logic       sda_pull_low,
  input logic       rd_pop,
  input logic       rx_empty,
  input logic       busy,
  input logic       rd_done,
  input logic       err
);
  a_r2_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_wr));

  a_r2_done_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_done);

  a_r5_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rd_done);

  a_r4_pull_in_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> (ack_phase && busy));

  a_r10_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rx_empty) |=> err);
endmodule

bind i2c_rx_burst i2c_rx_burst_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr       (ctl_wr),
  .ack_phase    (ack_phase),
  .sda_pull_low (sda_pull_low),
  .rd_pop       (rd_pop),
  .rx_empty     (rx_empty),
  .busy         (busy),
  .rd_done      (rd_done),
  .err          (err)
);

// File: tb/i2c_rx_burst_tb.sv
module i2c_rx_burst_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [6:0] ctl_count = '0;
  logic       ctl_nack_last = 1'b0;
  logic       irq_en = 1'b0;
  logic       bit_tick = 1'b0;
  logic       sda_in = 1'b0;
  logic       ack_phase, sda_pull_low;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rx_empty, busy, rd_done, err, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_rx_burst u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_count(ctl_count),
    .ctl_nack_last(ctl_nack_last), .irq_en(irq_en), .bit_tick(bit_tick),
    .sda_in(sda_in), .ack_phase(ack_phase), .sda_pull_low(sda_pull_low),
    .rd_pop(rd_pop), .rd_data(rd_data), .rx_empty(rx_empty), .busy(busy),
    .rd_done(rd_done), .err(err), .irq(irq)
  );

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 53 + k * 29 + 7) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input int cnt, input bit nl);
    ctl_count = 7'(cnt);
    ctl_nack_last = nl;
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_pull, input bit pop_too);
    for (int i = 0; i < 8; i++) begin
      sda_in = b[7-i];
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
    chk(ack_phase == 1'b1, "R3 ack_phase", int'(ack_phase), 1);
    chk(sda_pull_low == exp_pull, "R4 ack level", int'(sda_pull_low), int'(exp_pull));
    bit_tick = 1'b1;
    rd_pop = pop_too;
    @(negedge clk);
    bit_tick = 1'b0;
    rd_pop = 1'b0;
  endtask

  task automatic drain(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      chk(rx_empty == 1'b0, "R9 not empty", int'(rx_empty), 0);
      chk(rd_data == pat(seed, k), "R9 data order", int'(rd_data), int'(pat(seed, k)));
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    chk(rx_empty == 1'b1, "R9 empty after drain", int'(rx_empty), 1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && rd_done == 0 && err == 0 && irq == 0, "R1 flags", int'({busy, rd_done, err, irq}), 0);
    chk(ack_phase == 0 && sda_pull_low == 0, "R1 ack outputs", int'({ack_phase, sda_pull_low}), 0);
    chk(rx_empty == 1 && rd_data == 0, "R1 queue", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R9 sweep over counts and NACK policy
    for (int nl = 0; nl < 2; nl++) begin
      for (int n = 1; n <= 5; n++) begin
        irq_en = nl[0];
        start(n, nl[0]);
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(rd_done == 1'b0, "R2 done cleared", int'(rd_done), 0);
        for (int k = 0; k < n; k++) begin
          send_byte(pat(n * 2 + nl, k), (k < n - 1) ? 1'b1 : !nl[0], 1'b0);
          if (k < n - 1) chk(busy == 1'b1, "R2 busy mid burst", int'(busy), 1);
        end
        chk(busy == 1'b0, "R5 busy falls", int'(busy), 0);
        chk(rd_done == 1'b1, "R5 done set", int'(rd_done), 1);
        chk(irq == nl[0], "R5 irq gating", int'(irq), nl);
        drain(n, n * 2 + nl);
      end
    end

    // R6 zero count
    start(0, 0);
    chk(rd_done == 1'b1 && busy == 1'b0, "R6 immediate done", int'({rd_done, busy}), 2);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && ack_phase == 1'b0 && rx_empty == 1'b1, "R6 no bytes", int'({busy, ack_phase}), 0);

    // R8 control write during burst ignored
    start(3, 1);
    send_byte(pat(40, 0), 1'b1, 1'b0);
    ctl_count = 7'd1;
    ctl_nack_last = 1'b0;
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    send_byte(pat(40, 1), 1'b1, 1'b0);
    chk(busy == 1'b1, "R8 burst keeps count", int'(busy), 1);
    send_byte(pat(40, 2), 1'b0, 1'b0);
    chk(busy == 1'b0, "R8 ends on original count", int'(busy), 0);
    drain(3, 40);

    // R7 clamp to 64
    start(100, 0);
    for (int k = 0; k < 64; k++) send_byte(pat(50, k), 1'b1, 1'b0);
    chk(busy == 1'b0, "R7 clamped to 64", int'(busy), 0);
    chk(err == 1'b0, "R7 no error", int'(err), 0);

    // R11 push into full queue
    start(1, 0);
    send_byte(8'hA5, 1'b1, 1'b0);
    chk(err == 1'b1, "R11 overflow flag", int'(err), 1);
    drain(64, 50);

    // R10 underflow
    chk(err == 1'b1, "R10 err sticky", int'(err), 1);
    start(0, 0);
    chk(err == 1'b0, "R10 err cleared by start", int'(err), 0);
    chk(rd_data == 8'h00, "R10 empty reads zero", int'(rd_data), 0);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    chk(err == 1'b1, "R10 underflow flag", int'(err), 1);
    chk(rd_data == 8'h00 && rx_empty == 1'b1, "R10 still empty", int'(rd_data), 0);

    // R12 push and pop in the same cycle
    start(2, 1);
    send_byte(pat(60, 0), 1'b1, 1'b0);
    send_byte(pat(60, 1), 1'b0, 1'b1);
    chk(err == 1'b0, "R12 no error", int'(err), 0);
    chk(rx_empty == 1'b0 && rd_data == pat(60, 1), "R12 new byte only", int'(rd_data), int'(pat(60, 1)));
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    chk(rx_empty == 1'b1, "R12 single entry", int'(rx_empty), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule